// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block watches the stream of bus write cycles aimed at a NOR-style flash device. Each cycle carries an address, a data word and a write strobe. The block decides which command a run of writes forms. It recognises three things:

- the unlock handshake that has to come before every normal command;
- a word program, a whole-array erase and a single-sector erase;
- a persistent fast-program mode, called bypass mode.

When a sequence is complete, the block issues a single-cycle request to the embedded-algorithm engine that performs the operation. The request carries the latched program address and data, or the latched sector address.

A write that breaks a sequence sends the decoder back to read mode. The sequence must then be written again from the start. While the engine reports busy, every write is ignored. Once busy falls, the decoder returns to its base mode and clears the latched addresses. The base mode is normal or bypass.

In bypass mode the unlock prefix is no longer needed. A program takes only two writes: a program code, then the address and data. Only that program command and a two-write exit command are honoured in this mode.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset all request outputs are 0, `progAddr`, `progData` and `sectorAddr` are 0, and `bypassMode` is 0.
- R2: In normal mode, the writes 555h/AAh, then 2AAh/55h, then 555h/A0h, then any address/data pulse `progReq` high for exactly one cycle, the cycle after the fourth write. In that cycle `progAddr` and `progData` equal the fourth write. Unlock addresses are compared on address bits [10:0] and command codes on data bits [7:0].
- R3: In normal mode, the writes 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h, 555h/10h pulse `chipEraseReq` for one cycle, the cycle after the sixth write.
- R4: The same five-write prefix followed by data 30h at any address pulses `sectorEraseReq` for one cycle. In that cycle `sectorAddr` equals the sixth write's full address.
- R5: A write that does not match the expected address/data at any point of a normal sequence returns the decoder to read mode. A later write that would have completed the broken sequence issues no request.
- R6: The writes 555h/AAh, 2AAh/55h, 555h/20h set `bypassMode` to 1 from the cycle after the third write.
- R7: In bypass mode, data A0h at any address followed by any address/data pulses `progReq` with that address and data. No unlock writes are needed, and `bypassMode` stays 1.
- R8: In bypass mode, a write whose data is neither A0h nor 90h is ignored. This covers unlock and erase codes: no request is issued and `bypassMode` stays 1.
- R9: In bypass mode, data 90h followed by data 00h, at any addresses, clears `bypassMode`. Data 90h followed by anything else leaves bypass mode set.
- R10: No write is accepted while `engineBusy` is high. This includes the time from a request until busy falls. Such writes neither advance nor break a sequence.
- R11: When `engineBusy` is low after a request, the decoder returns to its base mode, and `progAddr`, `progData` and `sectorAddr` read 0 from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Bus write strobe, one cycle per write |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | DATA_W | Write data; command code in bits [7:0] |
| engineBusy | input | 1 | Embedded-algorithm engine busy |
| progReq | output | 1 | One-cycle program request |
| progAddr | output | ADDR_W | Latched program address |
| progData | output | DATA_W | Latched program data |
| chipEraseReq | output | 1 | One-cycle whole-array erase request |
| sectorEraseReq | output | 1 | One-cycle sector erase request |
| sectorAddr | output | ADDR_W | Latched sector erase address |
| bypassMode | output | 1 | Bypass fast-program mode active |

## Verification
A wrong sequence state stays hidden until the write that should complete a command. At that point it shows as a missing request, an extra request or a wrong latched value. The bench therefore pairs each broken or gated prefix with the write that would have finished it.

A wrong mode flag shows at `bypassMode` one cycle after the write that caused it. It also changes how the next A0h write is treated.

A run state that fails to release shows as latched addresses that stay nonzero after busy falls, and as later sequences that are silently swallowed. The bench compares every output against its model on every clock, so either fault is caught in the cycle it first appears.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  localparam int CMD_W = 8;

  localparam logic [CMD_W-1:0] CODE_KEY1   = 8'hAA;
  localparam logic [CMD_W-1:0] CODE_KEY2   = 8'h55;
  localparam logic [CMD_W-1:0] CODE_PROG   = 8'hA0;
  localparam logic [CMD_W-1:0] CODE_ESETUP = 8'h80;
  localparam logic [CMD_W-1:0] CODE_CHIP   = 8'h10;
  localparam logic [CMD_W-1:0] CODE_SECT   = 8'h30;
  localparam logic [CMD_W-1:0] CODE_BYPIN  = 8'h20;
  localparam logic [CMD_W-1:0] CODE_BYPOUT = 8'h90;
  localparam logic [CMD_W-1:0] CODE_ZERO   = 8'h00;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_KEY1,
    ST_KEY2,
    ST_PROGDATA,
    ST_ESETUP,
    ST_EKEY1,
    ST_EKEY2,
    ST_BYPEXIT,
    ST_RUN
  } fcdState_e;

  typedef struct packed {
    logic issueProg;
    logic issueChip;
    logic issueSect;
    logic releaseLatch;
    logic enterBypass;
    logic leaveBypass;
  } fcdStrobe_t;

endpackage

// File: rtl/fcd_ctrl.sv
module fcd_ctrl
  import fcd_pkg::*;
#(
  parameter int CMP_W = 11,
  parameter logic [CMP_W-1:0] KEY_ADDR1 = 11'h555,
  parameter logic [CMP_W-1:0] KEY_ADDR2 = 11'h2AA
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [CMP_W-1:0] cmpAddr,
  input  logic [CMD_W-1:0] cmdCode,
  input  logic             engineBusy,
  input  logic             bypassMode,
  output fcdStrobe_t       strobe
);

  fcdState_e state, stateNext;
  logic accept, isKey1, isKey2, atAddr1;

  assign accept  = wrEn && !engineBusy;
  assign atAddr1 = (cmpAddr == KEY_ADDR1);
  assign isKey1  = atAddr1 && (cmdCode == CODE_KEY1);
  assign isKey2  = (cmpAddr == KEY_ADDR2) && (cmdCode == CODE_KEY2);

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          if (bypassMode) begin
            if (cmdCode == CODE_PROG) stateNext = ST_PROGDATA;
            else if (cmdCode == CODE_BYPOUT) stateNext = ST_BYPEXIT;
          end else if (isKey1) begin
            stateNext = ST_KEY1;
          end
        end
      end
      ST_KEY1: if (accept) stateNext = isKey2 ? ST_KEY2 : ST_IDLE;
      ST_KEY2: begin
        if (accept) begin
          stateNext = ST_IDLE;
          if (atAddr1) begin
            if (cmdCode == CODE_PROG) stateNext = ST_PROGDATA;
            else if (cmdCode == CODE_ESETUP) stateNext = ST_ESETUP;
            else if (cmdCode == CODE_BYPIN) strobe.enterBypass = 1'b1;
          end
        end
      end
      ST_PROGDATA: begin
        if (accept) begin
          strobe.issueProg = 1'b1;
          stateNext = ST_RUN;
        end
      end
      ST_ESETUP: if (accept) stateNext = isKey1 ? ST_EKEY1 : ST_IDLE;
      ST_EKEY1:  if (accept) stateNext = isKey2 ? ST_EKEY2 : ST_IDLE;
      ST_EKEY2: begin
        if (accept) begin
          stateNext = ST_IDLE;
          if (atAddr1 && cmdCode == CODE_CHIP) begin
            strobe.issueChip = 1'b1;
            stateNext = ST_RUN;
          end else if (cmdCode == CODE_SECT) begin
            strobe.issueSect = 1'b1;
            stateNext = ST_RUN;
          end
        end
      end
      ST_BYPEXIT: begin
        if (accept) begin
          stateNext = ST_IDLE;
          if (cmdCode == CODE_ZERO) strobe.leaveBypass = 1'b1;
        end
      end
      ST_RUN: begin
        if (!engineBusy) begin
          strobe.releaseLatch = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/fcd_datapath.sv
module fcd_datapath
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  fcdStrobe_t        strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              progReq,
  output logic [ADDR_W-1:0] progAddr,
  output logic [DATA_W-1:0] progData,
  output logic              chipEraseReq,
  output logic              sectorEraseReq,
  output logic [ADDR_W-1:0] sectorAddr,
  output logic              bypassMode
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      progReq        <= 1'b0;
      chipEraseReq   <= 1'b0;
      sectorEraseReq <= 1'b0;
    end else begin
      progReq        <= strobe.issueProg;
      chipEraseReq   <= strobe.issueChip;
      sectorEraseReq <= strobe.issueSect;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.releaseLatch) begin
      progAddr   <= '0;
      progData   <= '0;
      sectorAddr <= '0;
    end else begin
      if (strobe.issueProg) begin
        progAddr <= wrAddr;
        progData <= wrData;
      end
      if (strobe.issueSect) sectorAddr <= wrAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   bypassMode <= 1'b0;
    else if (strobe.enterBypass) bypassMode <= 1'b1;
    else if (strobe.leaveBypass) bypassMode <= 1'b0;
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int CMP_W  = 11,
  parameter logic [CMP_W-1:0] KEY_ADDR1 = 11'h555,
  parameter logic [CMP_W-1:0] KEY_ADDR2 = 11'h2AA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              engineBusy,
  output logic              progReq,
  output logic [ADDR_W-1:0] progAddr,
  output logic [DATA_W-1:0] progData,
  output logic              chipEraseReq,
  output logic              sectorEraseReq,
  output logic [ADDR_W-1:0] sectorAddr,
  output logic              bypassMode
);

  fcdStrobe_t strobe;

  fcd_ctrl #(
    .CMP_W(CMP_W), .KEY_ADDR1(KEY_ADDR1), .KEY_ADDR2(KEY_ADDR2)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn),
    .cmpAddr(wrAddr[CMP_W-1:0]), .cmdCode(wrData[CMD_W-1:0]),
    .engineBusy(engineBusy), .bypassMode(bypassMode), .strobe(strobe)
  );

  fcd_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrAddr(wrAddr), .wrData(wrData),
    .progReq(progReq), .progAddr(progAddr), .progData(progData),
    .chipEraseReq(chipEraseReq), .sectorEraseReq(sectorEraseReq),
    .sectorAddr(sectorAddr), .bypassMode(bypassMode)
  );

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              engineBusy,
  input logic              progReq,
  input logic [ADDR_W-1:0] progAddr,
  input logic [DATA_W-1:0] progData,
  input logic              chipEraseReq,
  input logic              sectorEraseReq,
  input logic [ADDR_W-1:0] sectorAddr,
  input logic              bypassMode
);

  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({progReq, chipEraseReq, sectorEraseReq})); // R3

  AST_PROG_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    progReq |=> !progReq); // R2

  AST_PROG_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    progReq |-> (progAddr == $past(wrAddr) && progData == $past(wrData))); // R7

  AST_SECT_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    sectorEraseReq |-> sectorAddr == $past(wrAddr)); // R4

  AST_NO_ERASE_IN_BYPASS: assert property (@(posedge clk) disable iff (!rstN)
    (chipEraseReq || sectorEraseReq) |-> !bypassMode); // R8

  AST_BUSY_GATES: assert property (@(posedge clk) disable iff (!rstN)
    engineBusy |=> !(progReq || chipEraseReq || sectorEraseReq)); // R10

  AST_BYPASS_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bypassMode) |-> $past(wrEn && !engineBusy && wrData[7:0] == 8'h20)); // R6

  AST_BYPASS_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bypassMode) |-> $past(wrEn && !engineBusy && wrData[7:0] == 8'h00)); // R9

endmodule

bind flash_cmd_decoder fcd_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .engineBusy(engineBusy), .progReq(progReq), .progAddr(progAddr),
  .progData(progData), .chipEraseReq(chipEraseReq),
  .sectorEraseReq(sectorEraseReq), .sectorAddr(sectorAddr),
  .bypassMode(bypassMode)
);

// File: tb/tb_flash_cmd_decoder.sv
`timescale 1ns/1ps
module tb_flash_cmd_decoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [19:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        engineBusy = 1'b0;
  logic        progReq, chipEraseReq, sectorEraseReq, bypassMode;
  logic [19:0] progAddr, sectorAddr;
  logic [15:0] progData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit sbOn = 0;
  string curTag = "R1";
  int progCnt = 0, chipCnt = 0, sectCnt = 0;

  always #2 clk = ~clk;

  flash_cmd_decoder dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .engineBusy(engineBusy), .progReq(progReq), .progAddr(progAddr),
    .progData(progData), .chipEraseReq(chipEraseReq),
    .sectorEraseReq(sectorEraseReq), .sectorAddr(sectorAddr),
    .bypassMode(bypassMode)
  );

  // Reference model: history of accepted writes, matched against patterns
  int qa[$];
  int qd[$];
  bit mByp = 0, mRun = 0;
  int eProg = 0, eChip = 0, eSect = 0, eProgA = 0, eProgD = 0, eSectA = 0;

  function automatic bit lowIs(int i, int a, int d);
    return ((qa[i] & 32'h7FF) == a) && ((qd[i] & 32'hFF) == d);
  endfunction

  function automatic int codeOf(int i);
    return qd[i] & 32'hFF;
  endfunction

  always @(posedge clk) begin
    bit keep;
    int n;
    eProg = 0; eChip = 0; eSect = 0;
    if (!rstN) begin
      qa.delete(); qd.delete();
      mByp = 0; mRun = 0; eProgA = 0; eProgD = 0; eSectA = 0;
    end else if (mRun) begin
      if (!engineBusy) begin
        mRun = 0; eProgA = 0; eProgD = 0; eSectA = 0;
      end
    end else if (wrEn && !engineBusy) begin
      qa.push_back(int'(wrAddr));
      qd.push_back(int'(wrData));
      n = qa.size();
      keep = 0;
      if (mByp) begin
        if (n == 1) keep = (codeOf(0) == 'hA0) || (codeOf(0) == 'h90);
        else if (codeOf(0) == 'hA0) begin
          eProg = 1; eProgA = qa[1]; eProgD = qd[1]; mRun = 1;
        end else if (codeOf(1) == 0) mByp = 0;
      end else begin
        case (n)
          1: keep = lowIs(0, 'h555, 'hAA);
          2: keep = lowIs(1, 'h2AA, 'h55);
          3: if ((qa[2] & 32'h7FF) == 'h555) begin
               if (codeOf(2) == 'hA0 || codeOf(2) == 'h80) keep = 1;
               else if (codeOf(2) == 'h20) mByp = 1;
             end
          4: if (codeOf(2) == 'hA0) begin
               eProg = 1; eProgA = qa[3]; eProgD = qd[3]; mRun = 1;
             end else keep = lowIs(3, 'h555, 'hAA);
          5: keep = lowIs(4, 'h2AA, 'h55);
          default: begin
            if (lowIs(5, 'h555, 'h10)) begin eChip = 1; mRun = 1; end
            else if (codeOf(5) == 'h30) begin eSect = 1; eSectA = qa[5]; mRun = 1; end
          end
        endcase
      end
      if (!keep) begin qa.delete(); qd.delete(); end
    end
  end

  task automatic cmpField(string name, int act, int exp);
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", curTag, name, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (progReq) progCnt++;
    if (chipEraseReq) chipCnt++;
    if (sectorEraseReq) sectCnt++;
    if (sbOn) begin
      checks++;
      cmpField("progReq", int'(progReq), eProg);
      cmpField("chipEraseReq", int'(chipEraseReq), eChip);
      cmpField("sectorEraseReq", int'(sectorEraseReq), eSect);
      cmpField("progAddr", int'(progAddr), eProgA);
      cmpField("progData", int'(progData), eProgD);
      cmpField("sectorAddr", int'(sectorAddr), eSectA);
      cmpField("bypassMode", int'(bypassMode), int'(mByp));
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(int a, int d);
    wrEn = 1'b1; wrAddr = a[19:0]; wrData = d[15:0];
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic engine(int n);
    engineBusy = 1'b1;
    idle(n);
    engineBusy = 1'b0;
    idle(2);
  endtask

  task automatic unlock();
    wr('h555, 'hAA); wr('h2AA, 'h55);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int p0;
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    sbOn = 1;
    curTag = "R1";
    check("R1 progReq", int'(progReq), 0);
    check("R1 bypassMode", int'(bypassMode), 0);
    check("R1 sectorAddr", int'(sectorAddr), 0);

    curTag = "R2";
    unlock(); wr('h555, 'hA0); wr('h01234, 'hBEEF);
    check("R2 progReq", int'(progReq), 1);
    check("R2 progAddr", int'(progAddr), 'h01234);
    check("R2 progData", int'(progData), 'hBEEF);
    @(negedge clk);
    check("R2 pulse width", int'(progReq), 0);
    curTag = "R11";
    engine(4);
    check("R11 progAddr cleared", int'(progAddr), 0);
    check("R11 progData cleared", int'(progData), 0);

    curTag = "R3";
    unlock(); wr('h555, 'h80); unlock(); wr('h555, 'h10);
    check("R3 chipEraseReq", int'(chipEraseReq), 1);
    engine(6);

    curTag = "R4";
    unlock(); wr('h555, 'h80); unlock(); wr('h5A000, 'h30);
    check("R4 sectorEraseReq", int'(sectorEraseReq), 1);
    check("R4 sectorAddr", int'(sectorAddr), 'h5A000);
    curTag = "R11";
    engine(5);
    check("R11 sectorAddr cleared", int'(sectorAddr), 0);

    curTag = "R10";
    p0 = progCnt;
    unlock(); wr('h555, 'hA0); wr('h00100, 'h1111);
    engineBusy = 1'b1;
    unlock(); wr('h555, 'hA0); wr('h00200, 'h2222);
    engineBusy = 1'b0;
    idle(2);
    wr('h00300, 'h3333);
    idle(2);
    check("R10 writes under busy ignored", progCnt - p0, 1);
    engineBusy = 1'b1;
    unlock();
    engineBusy = 1'b0;
    wr('h555, 'hA0); wr('h00400, 'h4444);
    idle(2);
    check("R10 unlock under busy ignored", progCnt - p0, 1);
    engineBusy = 1'b1;
    wr('h555, 'hAA);
    engineBusy = 1'b0;
    unlock(); wr('h555, 'hA0); wr('h00500, 'h5555);
    check("R10 busy write does not break sequence", int'(progReq), 1);
    engine(3);

    curTag = "R5";
    p0 = progCnt;
    wr('h556, 'hAA); wr('h2AA, 'h55); wr('h555, 'hA0); wr('h00600, 'h6666);
    unlock(); wr('h555, 'h77); wr('h555, 'hA0); wr('h00700, 'h7777);
    idle(2);
    check("R5 broken program", progCnt - p0, 0);
    p0 = chipCnt;
    unlock(); wr('h555, 'h80); wr('h555, 'hAA); wr('h2AA, 'h54); wr('h555, 'h10);
    unlock(); wr('h555, 'h80); unlock(); wr('h554, 'h10);
    idle(2);
    check("R5 broken chip erase", chipCnt - p0, 0);

    curTag = "R6";
    unlock(); wr('h555, 'h20);
    check("R6 bypassMode set", int'(bypassMode), 1);

    curTag = "R7";
    wr('h7FFFF, 'hA0); wr('h0ABCD, 'hCAFE);
    check("R7 bypass progReq", int'(progReq), 1);
    check("R7 bypass progData", int'(progData), 'hCAFE);
    engine(3);
    wr('h00000, 'hA0); wr('h0ABCE, 'h0102);
    check("R7 second bypass program", int'(progAddr), 'h0ABCE);
    engine(3);
    check("R7 mode kept", int'(bypassMode), 1);

    curTag = "R8";
    p0 = chipCnt + sectCnt + progCnt;
    unlock(); wr('h555, 'h80); unlock(); wr('h555, 'h10); wr('h555, 'h30);
    idle(2);
    check("R8 no request in bypass", chipCnt + sectCnt + progCnt - p0, 0);
    check("R8 mode kept", int'(bypassMode), 1);

    curTag = "R9";
    wr('h123, 'h90); wr('h456, 'h55);
    check("R9 bad exit keeps bypass", int'(bypassMode), 1);
    wr('h123, 'h90); wr('h789, 'h00);
    check("R9 exit clears bypass", int'(bypassMode), 0);
    p0 = progCnt;
    wr('h555, 'hA0); wr('h00800, 'h8888);
    idle(2);
    check("R9 A0 needs unlock after exit", progCnt - p0, 0);

    idle(4);
    summary();
  end

endmodule